// File: doc/BRIEF.md
# Inband Loopback Code and PRBS Detector

This block watches a received T1 bit stream, one bit per accepted beat, and reports whether a known inband pattern is present. With the mode input low it hunts for two repeating loopback codes, an activate code and a deactivate code. Each code is judged over back-to-back observation windows of a fixed number of accepted bits. A code counts as present when a whole window carries it with fewer mismatches than a set limit, which is one percent of the window. With the mode input high it runs a self-synchronizing checker for a 2^15-1 pseudo-random sequence and reports whether the checker is locked.

The input is a valid/ready stream. The block never applies back-pressure: `in_ready` is always high, so every beat with `in_valid` high is accepted, and a beat with `in_valid` low carries nothing. Any change of the reported status raises a sticky change flag. The flag stays high until a write-one-to-clear pulse arrives. The default window is 51,200 bits with a limit of 512 mismatches, which is 33.16 ms at 1.544 Mbit/s. Both values are parameters.

Top module: `inband_lb_monitor`

## Requirements
- R1: After reset `act_det`, `deact_det` and `status_chg` are 0, and `in_ready` is 1 at all times.
- R2: Only beats with `in_valid` high are examined and counted. Data on a beat with `in_valid` low has no effect on the result of a window.
- R3: In loop mode (`prbs_mode`=0), a window of `WINDOW_BITS` accepted bits that repeats the activate code 00001 (leftmost bit received first), at any phase, with fewer than `ERR_LIMIT` mismatches sets `act_det` to 1. The output is visible after the clock edge that accepts the window's last bit.
- R4: In loop mode, a window that repeats the deactivate code 001 (leftmost bit first), at any phase, with fewer than `ERR_LIMIT` mismatches sets `deact_det` to 1 at the end of that window.
- R5: A window with `ERR_LIMIT` or more mismatches against a code, or with unrelated data, clears that code's status at the end of the window.
- R6: Loop-mode status changes only at window ends. Windows run back to back from reset or from a mode change.
- R7: `act_det` and `deact_det` are never 1 at the same time.
- R8: In PRBS mode (`prbs_mode`=1) the expected sequence obeys b[n] = b[n-14] XOR b[n-15]. Lock is reported on `act_det` and `deact_det` stays 0. Lock is never declared within 31 accepted bits of starting to hunt, and it is always declared after 47 consecutive correct bits.
- R9: In PRBS mode, an all-zero stream never produces lock.
- R10: Once locked, a run of 7 or fewer errors never drops lock. Lock drops when 8 errors fall inside one 64-bit block counted from lock, so 16 consecutive errors always drop it.
- R11: `status_chg` goes to 1 on the clock edge after any change of `act_det` or `deact_det`, and it stays 1.
- R12: A high `flag_clr` sampled at a clock edge clears `status_chg`. A new change detected at the same edge wins, and the flag stays 1.
- R13: A change of `prbs_mode` restarts both engines at the next edge. The outputs go to 0 and `status_chg` does not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Beat on `in_bit` is valid |
| in_ready | output | 1 | Always 1; no back-pressure |
| in_bit | input | 1 | Received line bit |
| prbs_mode | input | 1 | 0 = loopback codes, 1 = PRBS lock |
| flag_clr | input | 1 | Write-one-to-clear for `status_chg` |
| act_det | output | 1 | Activate code present, or PRBS locked |
| deact_det | output | 1 | Deactivate code present (loop mode only) |
| status_chg | output | 1 | Sticky status-change flag |

## Verification
The bench targets the mismatch threshold from both sides. A window with limit-minus-one errors must keep the code detected and one with exactly the limit must drop it; an off-by-one comparison would flip one of those results. The codes start at random phases and idle beats carry random data. A matcher locked to a single phase, or one that counts idle beats, would then miss detections or lose them. In PRBS mode the bench checks that lock cannot appear too early or on an all-zero line, that seven scattered errors leave lock in place, and that sixteen in a row remove it. A checker that resynchronizes on every error, or never unlocks, fails there. The flag is checked for set-wins against a clear in the same cycle and for staying quiet across a mode switch.

// File: rtl/ilb_pkg.sv
package ilb_pkg;
  typedef enum logic {
    MODE_LOOP = 1'b0,
    MODE_PRBS = 1'b1
  } ilb_mode_e;

  typedef struct packed {
    logic act;
    logic deact;
  } ilb_status_t;
endpackage

// File: rtl/ilb_code_matcher.sv
// Windowed matcher for one repeating code; every phase is scored in parallel.
module ilb_code_matcher #(
  parameter int CODE_LEN    = 5,
  parameter logic [CODE_LEN-1:0] CODE = 5'b00001,
  parameter int WINDOW_BITS = 51200,
  parameter int ERR_LIMIT   = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic bit_vld,
  input  logic bit_in,
  output logic det
);
  localparam int WIN_W = $clog2(WINDOW_BITS);
  localparam int POS_W = (CODE_LEN > 1) ? $clog2(CODE_LEN) : 1;
  localparam int CNT_W = $clog2(ERR_LIMIT + 1);

  logic [WIN_W-1:0]    win_cnt;
  logic [POS_W-1:0]    pos;
  logic                win_last;
  logic [CODE_LEN-1:0] pass;

  assign win_last = bit_vld && (win_cnt == WIN_W'(WINDOW_BITS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      win_cnt <= '0;
      pos     <= '0;
    end else if (bit_vld) begin
      win_cnt <= win_last ? '0 : win_cnt + 1'b1;
      pos     <= (pos == POS_W'(CODE_LEN - 1)) ? '0 : pos + 1'b1;
    end
  end

  for (genvar k = 0; k < CODE_LEN; k++) begin : g_phase
    localparam logic [CODE_LEN-1:0] ROT =
      CODE_LEN'((CODE << k) | (CODE >> (CODE_LEN - k)));
    logic             exp_bit;
    logic             mism;
    logic [CNT_W-1:0] err_cnt;

    assign exp_bit = ROT[POS_W'(CODE_LEN - 1) - pos];
    assign mism    = bit_in ^ exp_bit;
    assign pass[k] = ({1'b0, err_cnt} + (CNT_W+1)'(mism)) < (CNT_W+1)'(ERR_LIMIT);

    always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
        err_cnt <= '0;
      end else if (bit_vld) begin
        if (win_last)
          err_cnt <= '0;
        else if (err_cnt != CNT_W'(ERR_LIMIT))
          err_cnt <= err_cnt + CNT_W'(mism);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr)
      det <= 1'b0;
    else if (win_last)
      det <= |pass;
  end

  // R6
  det_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_last && !clr) |=> $stable(det));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_vld && !clr) |=> ($stable(win_cnt) && $stable(pos)));
endmodule

// File: rtl/ilb_prbs_sync.sv
// Self-synchronizing PRBS checker with run-length lock and block-based loss.
module ilb_prbs_sync #(
  parameter int PRBS_ORDER = 15,
  parameter int PRBS_TAP   = 14,
  parameter int LOCK_RUN   = 32,
  parameter int LOSE_ERRS  = 8,
  parameter int LOSE_SPAN  = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic bit_vld,
  input  logic bit_in,
  output logic locked
);
  localparam int RUN_W  = $clog2(LOCK_RUN + 1);
  localparam int SPAN_W = $clog2(LOSE_SPAN);
  localparam int ERR_W  = $clog2(LOSE_ERRS + 1);

  logic [PRBS_ORDER-1:0] hist;
  logic [RUN_W-1:0]      run_cnt;
  logic [SPAN_W-1:0]     span_cnt;
  logic [ERR_W-1:0]      err_cnt;
  logic                  pred;
  logic                  good;
  logic                  span_end;

  assign pred     = hist[PRBS_ORDER-1] ^ hist[PRBS_TAP-1];
  assign good     = (bit_in == pred);
  assign span_end = (span_cnt == SPAN_W'(LOSE_SPAN - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      hist     <= '0;
      run_cnt  <= '0;
      span_cnt <= '0;
      err_cnt  <= '0;
      locked   <= 1'b0;
    end else if (bit_vld) begin
      if (!locked) begin
        hist <= {hist[PRBS_ORDER-2:0], bit_in};
        if (good && (hist != '0)) begin
          if (run_cnt == RUN_W'(LOCK_RUN - 1)) begin
            locked   <= 1'b1;
            run_cnt  <= '0;
            span_cnt <= '0;
            err_cnt  <= '0;
          end else begin
            run_cnt <= run_cnt + 1'b1;
          end
        end else begin
          run_cnt <= '0;
        end
      end else begin
        hist     <= {hist[PRBS_ORDER-2:0], pred};
        span_cnt <= span_end ? '0 : span_cnt + 1'b1;
        if (!good && (err_cnt == ERR_W'(LOSE_ERRS - 1))) begin
          locked   <= 1'b0;
          run_cnt  <= '0;
          span_cnt <= '0;
          err_cnt  <= '0;
        end else if (span_end) begin
          err_cnt <= '0;
        end else begin
          err_cnt <= err_cnt + ERR_W'(!good);
        end
      end
    end
  end

  // R9
  prbs_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> (hist != '0));

  // R8
  lock_on_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(bit_vld));

  // R10
  lock_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !bit_vld && !clr) |=> locked);
endmodule

// File: rtl/ilb_status_flag.sv
// Sticky change flag over the reported status pair.
module ilb_status_flag
  import ilb_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hold,
  input  logic        clr_req,
  input  ilb_status_t cur,
  output logic        flag
);
  ilb_status_t prev;
  logic        changed;

  assign changed = (cur != prev);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev <= '0;
      flag <= 1'b0;
    end else if (hold) begin
      prev <= '0;
      if (clr_req) flag <= 1'b0;
    end else begin
      prev <= cur;
      if (changed)      flag <= 1'b1;
      else if (clr_req) flag <= 1'b0;
    end
  end

  // R11
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (changed && !hold) |=> flag);

  // R12
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !changed) |=> !flag);

  // R11
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr_req) |=> flag);
endmodule

// File: rtl/inband_lb_monitor.sv
module inband_lb_monitor
  import ilb_pkg::*;
#(
  parameter int WINDOW_BITS = 51200,
  parameter int ERR_LIMIT   = 512,
  parameter int ACT_LEN     = 5,
  parameter logic [ACT_LEN-1:0] ACT_CODE = 5'b00001,
  parameter int DEACT_LEN   = 3,
  parameter logic [DEACT_LEN-1:0] DEACT_CODE = 3'b001,
  parameter int PRBS_ORDER  = 15,
  parameter int PRBS_TAP    = 14,
  parameter int LOCK_RUN    = 32,
  parameter int LOSE_ERRS   = 8,
  parameter int LOSE_SPAN   = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic in_ready,
  input  logic in_bit,
  input  logic prbs_mode,
  input  logic flag_clr,
  output logic act_det,
  output logic deact_det,
  output logic status_chg
);
  ilb_mode_e   mode_q;
  ilb_mode_e   mode_in;
  logic        mode_chg;
  logic        loop_clr;
  logic        prbs_clr;
  logic        accept;
  logic        act_hit;
  logic        deact_hit;
  logic        prbs_lock;
  ilb_status_t status;

  assign in_ready = 1'b1;
  assign accept   = in_valid && in_ready;
  assign mode_in  = ilb_mode_e'(prbs_mode);
  assign mode_chg = (mode_in != mode_q);
  assign loop_clr = mode_chg || (mode_q != MODE_LOOP);
  assign prbs_clr = mode_chg || (mode_q != MODE_PRBS);

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= MODE_LOOP;
    else        mode_q <= mode_in;
  end

  ilb_code_matcher #(
    .CODE_LEN(ACT_LEN), .CODE(ACT_CODE),
    .WINDOW_BITS(WINDOW_BITS), .ERR_LIMIT(ERR_LIMIT)
  ) u_act (
    .clk(clk), .rst_n(rst_n), .clr(loop_clr),
    .bit_vld(accept), .bit_in(in_bit), .det(act_hit)
  );

  ilb_code_matcher #(
    .CODE_LEN(DEACT_LEN), .CODE(DEACT_CODE),
    .WINDOW_BITS(WINDOW_BITS), .ERR_LIMIT(ERR_LIMIT)
  ) u_deact (
    .clk(clk), .rst_n(rst_n), .clr(loop_clr),
    .bit_vld(accept), .bit_in(in_bit), .det(deact_hit)
  );

  ilb_prbs_sync #(
    .PRBS_ORDER(PRBS_ORDER), .PRBS_TAP(PRBS_TAP), .LOCK_RUN(LOCK_RUN),
    .LOSE_ERRS(LOSE_ERRS), .LOSE_SPAN(LOSE_SPAN)
  ) u_prbs (
    .clk(clk), .rst_n(rst_n), .clr(prbs_clr),
    .bit_vld(accept), .bit_in(in_bit), .locked(prbs_lock)
  );

  always_comb begin
    if (mode_q == MODE_PRBS) begin
      status.act   = prbs_lock;
      status.deact = 1'b0;
    end else begin
      status.act   = act_hit;
      status.deact = deact_hit;
    end
  end

  assign act_det   = status.act;
  assign deact_det = status.deact;

  ilb_status_flag u_flag (
    .clk(clk), .rst_n(rst_n), .hold(mode_chg),
    .clr_req(flag_clr), .cur(status), .flag(status_chg)
  );

  // R7
  excl_det_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(act_det && deact_det));

  // R8
  prbs_deact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_PRBS) |-> !deact_det);

  // R13
  mode_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> (!act_det && !deact_det));

  // R13
  mode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_chg && !status_chg) |=> !status_chg);
endmodule

// File: tb/test_inband_lb_monitor.sv
module test_inband_lb_monitor;
  localparam int WIN = 400;
  localparam int LIM = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic in_bit = 1'b0;
  logic prbs_mode = 1'b0;
  logic flag_clr = 1'b0;
  logic act_det, deact_det, status_chg;

  int tests = 0;
  int fails = 0;
  int pidx;
  logic exp_act = 1'b0, exp_deact = 1'b0, exp_flag = 1'b0;
  logic [14:0] pg;
  int seed_sink;

  always #5 clk = ~clk;

  inband_lb_monitor #(.WINDOW_BITS(WIN), .ERR_LIMIT(LIM)) i_inband_lb_monitor (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_bit(in_bit), .prbs_mode(prbs_mode), .flag_clr(flag_clr),
    .act_det(act_det), .deact_det(deact_det), .status_chg(status_chg)
  );

  task automatic chk(input string req, input logic got, input logic want);
    tests++;
    if (got !== want) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, want, $time);
    end
  endtask

  // sel 0: activate code, 1: deactivate code, 2: random data
  function automatic logic pat_bit(input int sel, input int idx);
    if (sel == 0) return (idx % 5) == 4;
    if (sel == 1) return (idx % 3) == 2;
    return 1'($urandom_range(0, 1));
  endfunction

  function automatic logic prbs_next();
    logic nb;
    nb = pg[13] ^ pg[14];
    pg = {pg[13:0], nb};
    return nb;
  endfunction

  // R2: idle beats carry random data that must be ignored
  task automatic send_bit(input logic b);
    if ($urandom_range(0, 3) == 0) begin
      in_valid = 1'b0;
      in_bit   = 1'($urandom_range(0, 1));
      @(negedge clk);
    end
    in_valid = 1'b1;
    in_bit   = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pulse_clr();
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    exp_flag = 1'b0;
  endtask

  task automatic send_window(input int sel, input int nerr, input bit mid_chk, input bit clr_at_end);
    int spacing, off;
    logic b, na, nd, chg;
    spacing = WIN / ((nerr > 0) ? nerr : 1);
    off = $urandom_range(0, spacing - 1);
    for (int i = 0; i < WIN; i++) begin
      if (mid_chk && i == WIN / 2) begin
        chk("R6 mid-window act", act_det, exp_act);
        chk("R6 mid-window deact", deact_det, exp_deact);
      end
      b = pat_bit(sel, pidx);
      if (nerr > 0 && (i % spacing) == off && (i / spacing) < nerr) b = ~b;
      send_bit(b);
      pidx++;
    end
    na  = (sel == 0) && (nerr < LIM);
    nd  = (sel == 1) && (nerr < LIM);
    chg = (na != exp_act) || (nd != exp_deact);
    exp_act = na;
    exp_deact = nd;
    chk("R3 act at window end", act_det, exp_act);
    chk("R4 deact at window end", deact_det, exp_deact);
    chk("R7 exclusive", act_det & deact_det, 1'b0);
    if (clr_at_end) begin
      flag_clr = 1'b1;
      @(negedge clk);
      flag_clr = 1'b0;
      exp_flag = chg;
      chk("R12 set wins over clear", status_chg, exp_flag);
    end else begin
      @(negedge clk);
      if (chg) exp_flag = 1'b1;
      chk("R11 flag after window", status_chg, exp_flag);
    end
  endtask

  task automatic send_prbs(input int n, input int flip_from, input int flip_cnt, input int flip_step);
    logic b;
    for (int i = 0; i < n; i++) begin
      b = prbs_next();
      if (i >= flip_from && i < flip_from + flip_cnt * flip_step && ((i - flip_from) % flip_step) == 0)
        b = ~b;
      send_bit(b);
    end
  endtask

  task automatic switch_mode(input logic m);
    prbs_mode = m;
    @(negedge clk);
    chk("R13 act cleared on mode change", act_det, 1'b0);
    chk("R13 deact cleared on mode change", deact_det, 1'b0);
    @(negedge clk);
    chk("R13 no flag from mode change", status_chg, exp_flag);
    exp_act = 1'b0;
    exp_deact = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    seed_sink = $urandom(32'h5EED_1234);
    pidx = $urandom_range(0, 29);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 act after reset", act_det, 1'b0);
    chk("R1 deact after reset", deact_det, 1'b0);
    chk("R1 flag after reset", status_chg, 1'b0);
    chk("R1 ready", in_ready, 1'b1);

    // loop mode directed cases
    send_window(0, 0, 1'b0, 1'b0);          // R3 detect activate
    pulse_clr();
    chk("R12 clear", status_chg, 1'b0);
    send_window(0, LIM - 1, 1'b1, 1'b0);    // R5 one below limit keeps it
    send_window(0, LIM, 1'b1, 1'b0);        // R5 at limit drops it, R6 mid check
    pulse_clr();
    pidx = pidx + $urandom_range(1, 2);
    send_window(1, 0, 1'b0, 1'b0);          // R4 deactivate at new phase
    pulse_clr();
    send_window(2, 0, 1'b0, 1'b1);          // R12 drop with clear same cycle
    send_window(1, LIM - 1, 1'b0, 1'b0);

    // constrained random windows
    for (int w = 0; w < 8; w++) begin
      pidx = pidx + $urandom_range(0, 4);
      send_window($urandom_range(0, 2), $urandom_range(0, 6), 1'b1, 1'($urandom_range(0, 1)));
    end

    // R13: leave loop mode while activate is reported
    send_window(0, 0, 1'b0, 1'b0);
    pulse_clr();
    chk("R3 act before mode change", act_det, 1'b1);
    switch_mode(1'b1);

    // R9: zeros never lock
    for (int i = 0; i < 200; i++) send_bit(1'b0);
    chk("R9 zeros no lock", act_det, 1'b0);

    // R8: lock timing
    pg = 15'h1ACE ^ 15'($urandom_range(0, 255));
    if (pg == '0) pg = 15'h1;
    send_prbs(31, 0, 0, 1);
    chk("R8 no lock within 31 bits", act_det, 1'b0);
    send_prbs(16, 0, 0, 1);
    chk("R8 lock after 47 bits", act_det, 1'b1);
    chk("R8 deact stays low", deact_det, 1'b0);
    @(negedge clk);
    chk("R11 flag on lock", status_chg, 1'b1);
    pulse_clr();

    // R10: 7 scattered errors keep lock
    send_prbs(200, 20, 7, 9);
    chk("R10 lock kept with 7 errors", act_det, 1'b1);
    @(negedge clk);
    chk("R11 no flag without change", status_chg, 1'b0);

    // R10: 16 consecutive errors drop lock
    send_prbs(16, 0, 16, 1);
    chk("R10 lock lost after 16 errors", act_det, 1'b0);
    @(negedge clk);
    chk("R11 flag on lock loss", status_chg, 1'b1);
    send_prbs(60, 0, 0, 1);
    chk("R8 relock", act_det, 1'b1);
    pulse_clr();

    // back to loop mode
    switch_mode(1'b0);
    pidx = $urandom_range(0, 29);
    send_window(1, 0, 1'b0, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule